// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block lets a clocked master read and write an external asynchronous static RAM of 131,072 eight-bit words. The master sees a request/ready handshake. When ready is high it presents a 17-bit address, a read/write flag and, for writes, one data byte. A read returns its byte with a one-clock valid pulse. On the memory side the controller drives the address, a shared bidirectional data bus and four control lines: a low-true select, a high-true enable, a low-true write strobe and a low-true output gate. The memory only operates while select is low and enable is high.

Bus timing is given in nanoseconds through parameters: the clock period, the cycle and access time, the output-gate access time and the output-disable time. These are rounded up to whole clocks, so the same code serves the faster and the slower speed grade. Every access ends with a recovery phase of at least the disable time. In that phase neither side drives the bus. The controller then drops back to standby, with select high and enable low, which is the lowest-power state of the memory.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, the controls are at standby: select high (1), enable low (0), write strobe high (1), output gate high (1). The controller does not drive the data bus, and ready is 1.
- R2: Whenever ready is high, select is high and enable is low (standby encoding).
- R3: A write holds the write strobe low for exactly RD_CYC clocks, where RD_CYC is the larger of ceil(T_RC_NS/CLK_NS) and ceil(T_OE_NS/CLK_NS); this is 4 with the default parameters. Throughout that time select is low, enable is high and the output gate is high. The controller drives the write byte on the data bus only while the write strobe is low.
- R4: The address and the data byte on the bus do not change while the write strobe is low.
- R5: The address does not change in the clock after the write strobe rises.
- R6: The output gate goes low only while the write strobe is high, select is low and enable is high, and only while the controller is not driving the bus.
- R7: A read samples the bus exactly RD_CYC clocks after the address and controls go active. Read-data-valid rises RD_CYC+1 falling clock edges after the request is presented. It carries the byte stored at that address.
- R8: Between the controller releasing the bus and any falling edge of the output gate, at least DIS_CYC = ceil(T_DIS_NS/CLK_NS) quiet clocks pass (2 by default). For a write followed directly by a read, this gap is at least DIS_CYC+1 clocks.
- R9: Read-data-valid is high for exactly one clock per read.
- R10: A request is accepted only when ready is high, and ready drops on the clock after acceptance. A request presented while ready is low has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 8 | Byte captured by a read |
| mem_addr | output | 17 | Address to the memory |
| mem_dq | inout | 8 | Bidirectional memory data bus |
| mem_sel_n | output | 1 | Low-true memory select |
| mem_en | output | 1 | High-true memory enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output gate |

## Verification
Two events can fall on the same clock edge. One is the end of a write's recovery phase, when ready returns high. The other is the start of a read, where the output gate falls on the memory. This is provoked by issuing a read on the first idle cycle after a write to the same address. It is judged by counting the clocks from the rise of the write strobe to the fall of the output gate, and by checking that the read returns the byte just written. The memory model in the bench returns a corrupted byte until the access time has elapsed, so a controller that samples one clock early is caught.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_REC} st_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 4,
  parameter int DIS_CYC = 2,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output logic          ready,
  output logic          sel_n,
  output logic          en,
  output logic          we_n,
  output logic          oe_n,
  output logic          drive
);
  localparam logic [CW-1:0] ACC_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(DIS_CYC - 1);

  st_e state;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign capture  = (state == ST_RD) && tmr_zero;
  assign tmr_load = accept || (((state == ST_RD) || (state == ST_WR)) && tmr_zero);
  assign tmr_val  = accept ? ACC_LOAD : REC_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ready <= 1'b1;
      sel_n <= 1'b1;
      en    <= 1'b0;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      drive <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          ready <= 1'b0;
          sel_n <= 1'b0;
          en    <= 1'b1;
          if (req_write) begin
            we_n  <= 1'b0;
            drive <= 1'b1;
            state <= ST_WR;
          end else begin
            oe_n  <= 1'b0;
            state <= ST_RD;
          end
        end
        ST_RD: if (tmr_zero) begin
          oe_n  <= 1'b1;
          state <= ST_REC;
        end
        ST_WR: if (tmr_zero) begin
          we_n  <= 1'b1;
          drive <= 1'b0;
          state <= ST_REC;
        end
        ST_REC: if (tmr_zero) begin
          sel_n <= 1'b1;
          en    <= 1'b0;
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= bus_in;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 30,
  parameter int T_OE_NS   = 12,
  parameter int T_DIS_NS  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq,
  output logic          mem_sel_n,
  output logic          mem_en,
  output logic          mem_we_n,
  output logic          mem_oe_n
);
  localparam int RC_CYC  = imax(1, ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int OE_CYC  = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int RD_CYC  = imax(RC_CYC, OE_CYC);
  localparam int DIS_CYC = imax(1, ns_to_cyc(T_DIS_NS, CLK_NS));
  localparam int CW      = $clog2(imax(RD_CYC, DIS_CYC) + 1);

  logic          tmr_load, tmr_zero, accept, capture, bus_drive;
  logic [CW-1:0] tmr_val;
  logic [DW-1:0] wdata_q;

  asram_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  asram_seq #(.RD_CYC(RD_CYC), .DIS_CYC(DIS_CYC), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .accept(accept), .capture(capture), .ready(req_ready),
    .sel_n(mem_sel_n), .en(mem_en), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .drive(bus_drive)
  );

  asram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_in(mem_dq),
    .addr_q(mem_addr), .wdata_q(wdata_q), .rdata_q(rsp_rdata),
    .rvalid_q(rsp_valid)
  );

  assign mem_dq = bus_drive ? wdata_q : {DW{1'bz}};
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int DIS_CYC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_sel_n,
  input logic          mem_en,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          bus_drive,
  input logic [DW-1:0] wdata
);
  localparam int QW = $clog2(DIS_CYC + 2) + 1;
  localparam logic [QW-1:0] QMAX = {QW{1'b1}};

  logic [QW-1:0] quiet;
  always_ff @(posedge clk) begin
    if (rst)                                  quiet <= QMAX;
    else if (bus_drive || !mem_we_n)          quiet <= '0;
    else if (quiet != QMAX)                   quiet <= quiet + 1'b1;
  end

  assert_reset_standby_R1: assert property (@(posedge clk)
    rst |=> (mem_sel_n && !mem_en && mem_we_n && mem_oe_n && !bus_drive && req_ready));

  assert_idle_standby_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel_n && !mem_en));

  assert_write_encoding_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_sel_n && mem_en && mem_oe_n && bus_drive));

  assert_drive_only_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> !mem_we_n);

  assert_write_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(wdata)));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> $stable(mem_addr));

  assert_read_encoding_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_sel_n && mem_en && !bus_drive));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> (quiet >= QW'(DIS_CYC)));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_accept_drops_ready_R10: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> !req_ready);
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW), .DIS_CYC(DIS_CYC)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
  .mem_en(mem_en), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .bus_drive(bus_drive), .wdata(wdata_q)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RD_CYC  = (30 + 7) / 8;
  localparam int DIS_CYC = (10 + 7) / 8;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;
  logic mem_sel_n, mem_en, mem_we_n, mem_oe_n;

  always #4 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_sel_n(mem_sel_n), .mem_en(mem_en),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  // memory model: 256 bytes indexed by the low address byte
  logic [DW-1:0] mem [256];
  logic rd_mode, wr_mode, rd_prev;
  logic [AW-1:0] addr_prev;
  int age;
  assign rd_mode = mem_en && !mem_sel_n && mem_we_n && !mem_oe_n;
  assign wr_mode = mem_en && !mem_sel_n && !mem_we_n;
  assign mem_dq = rd_mode ? ((age >= RD_CYC - 1) ? mem[mem_addr[7:0]] : ~mem[mem_addr[7:0]])
                          : {DW{1'bz}};
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(posedge clk) begin
    if (wr_mode) mem[mem_addr[7:0]] <= mem_dq;
    if (rd_mode) age <= (rd_prev && mem_addr == addr_prev) ? age + 1 : 1;
    else         age <= 0;
    rd_prev   <= rd_mode;
    addr_prev <= mem_addr;
  end

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // strobe monitor at falling edges
  logic [AW-1:0] exp_wa = '0;
  logic [DW-1:0] exp_wd = '0;
  int we_len = 0, we_rise_cyc = -100;
  bit we_prev = 1, oe_prev = 1, turn_chk = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!mem_we_n) begin
        we_len++;
        chk(mem_addr == exp_wa, "R4", "write address", int'(mem_addr), int'(exp_wa));
        chk(mem_dq == exp_wd, "R4", "write data", int'(mem_dq), int'(exp_wd));
      end else if (!we_prev) begin
        chk(we_len == RD_CYC, "R3", "strobe length", we_len, RD_CYC);
        chk(mem_addr == exp_wa, "R5", "address after strobe", int'(mem_addr), int'(exp_wa));
        we_len = 0;
        we_rise_cyc = cyc;
      end
      if (!mem_oe_n && oe_prev && turn_chk) begin
        chk(cyc - we_rise_cyc >= DIS_CYC + 1, "R8", "turnaround gap",
            cyc - we_rise_cyc, DIS_CYC + 1);
        turn_chk = 0;
      end
    end
    we_prev = mem_we_n;
    oe_prev = mem_oe_n;
  end

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wait_ready();
    exp_wa = a; exp_wd = d;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10", "ready after write accept", req_ready, 0);
    chk(!mem_we_n && mem_oe_n && !mem_sel_n && mem_en, "R3", "write controls",
        {mem_we_n, mem_oe_n, mem_sel_n, mem_en}, 4'b0101);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
    int lat;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    chk(mem_we_n && !mem_oe_n && !mem_sel_n && mem_en, "R6", "read controls",
        {mem_we_n, mem_oe_n, mem_sel_n, mem_en}, 4'b1001);
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    chk(lat == RD_CYC + 1, "R7", "read latency", lat, RD_CYC + 1);
    chk(rsp_rdata == e, "R7", "read data", int'(rsp_rdata), int'(e));
    @(negedge clk);
    chk(!rsp_valid, "R9", "valid pulse width", rsp_valid, 0);
  endtask

  // {write, addr, data}
  localparam logic [AW+DW:0] VEC [NV] = '{
    {1'b1, 17'h00011, 8'hA5}, {1'b1, 17'h1FF22, 8'h3C},
    {1'b1, 17'h0AB33, 8'hFF}, {1'b1, 17'h10044, 8'h00},
    {1'b0, 17'h00011, 8'hA5}, {1'b0, 17'h1FF22, 8'h3C},
    {1'b0, 17'h0AB33, 8'hFF}, {1'b0, 17'h10044, 8'h00},
    {1'b1, 17'h00011, 8'h5A}, {1'b0, 17'h00011, 8'h5A},
    {1'b0, 17'h1FF22, 8'h3C}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_sel_n && !mem_en && mem_we_n && mem_oe_n, "R1", "controls in reset",
        {mem_sel_n, mem_en, mem_we_n, mem_oe_n}, 4'b1011);
    chk(req_ready, "R1", "ready in reset", req_ready, 1);
    rst = 0;
    @(negedge clk);
    chk(mem_sel_n && !mem_en && mem_we_n && mem_oe_n && req_ready, "R1",
        "state after reset", {mem_sel_n, mem_en, mem_we_n, mem_oe_n}, 4'b1011);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][AW+DW]) do_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
      else begin
        if (i > 0 && VEC[i-1][AW+DW]) turn_chk = 1;
        do_read(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
      end
      wait_ready();
      chk(mem_sel_n && !mem_en, "R2", "standby when ready", {mem_sel_n, mem_en}, 2'b10);
    end

    // request while busy must be ignored (R10)
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = 17'h0AB33;
    @(negedge clk);
    req_write = 1; req_addr = 17'h00011; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 8'hFF, "R7", "read beside busy request", int'(rsp_rdata), 8'hFF);
    do_read(17'h00011, 8'h5A);
    chk(mem[8'h11] == 8'h5A, "R10", "memory untouched by busy request",
        int'(mem[8'h11]), 8'h5A);

    // back-to-back write then read of a new address (R8)
    do_write(17'h01066, 8'h77);
    turn_chk = 1;
    do_read(17'h01066, 8'h77);
    chk(!turn_chk, "R8", "turnaround observed", turn_chk, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R7: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule